// File: doc/BRIEF.md
# Synchronized SPI Byte Slave

This block is a byte-wide serial slave that an external master clocks. Each frame carries eight bits, most significant bit first, in both directions. The serial clock, the select line and the serial input pass through a two-flop synchronizer into the system clock domain, and all edge detection happens there. The system clock must therefore run at least four times faster than the serial clock.

On the register side, a write strobe loads the next byte to transmit and a read strobe takes the last received byte. A 4-bit mode code chooses whether the select line gates the slave. Two bits set the clock idle level and the edge on which data changes. Status flags report a completed byte, an overflow, a write collision and an illegal edge choice.

Raising the select line (in select-gated mode) or clearing the enable stops the frame at once. The partial byte is dropped, the bit counter returns to zero and the serial output floats. The next frame therefore starts aligned.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, irqFlag, ovfFlag, wcolFlag and sdoOe are 0 and bufRdData is 0x00.
- R2: The byte received MSB first appears on bufRdData and irqFlag is set once the eighth bit is sampled. This holds for all four cpol/cke settings. cpol is the sck idle level. With cke=1, sampling is on the idle-to-active edge and data changes on the active-to-idle edge. With cke=0, the two edges swap roles.
- R3: The byte written through bufWr is shifted out on sdo MSB first, and its bit 7 is on sdo before the first clock edge.
- R4: A frame that has no fresh bufWr before it sends 0x00, because a completed frame empties the transmit register.
- R5: With mode code 4'b0100, ssN high clears the bit counter and drops sdoOe to 0. A partial frame is discarded and causes no irqFlag, and the next full frame is received aligned.
- R6: With any other mode code, ssN is ignored and the slave is selected whenever enable is 1.
- R7: enable=0 drops sdoOe and clears the bit counter, so a partial frame is discarded.
- R8: cke=1 with a mode code other than 4'b0100 raises modeErr (while enabled), and the slave then behaves as with cke=0.
- R9: If a byte completes while the previous one is unread, ovfFlag is set, bufRdData keeps the old byte, and irqFlag is still set.
- R10: A bufRd in the same cycle as a byte completion counts as reading the old byte. No overflow results, the new byte is stored, and it counts as unread.
- R11: bufWr while a frame is part-way through (1 to 7 bits sampled) sets wcolFlag and leaves the transmit register unchanged.
- R12: flagClr clears irqFlag, ovfFlag and wcolFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| ssN | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (valid when sdoOe=1) |
| sdoOe | output | 1 | Output enable for sdo; 0 means high impedance |
| bufWr | input | 1 | Write strobe loading the transmit register |
| bufWrData | input | 8 | Byte to transmit |
| bufRd | input | 1 | Read strobe marking the received byte as taken |
| bufRdData | output | 8 | Last stored received byte |
| mode | input | 4 | Mode code; 4'b0100 enables select gating |
| cpol | input | 1 | sck idle level |
| cke | input | 1 | Edge select (1: change on active-to-idle) |
| enable | input | 1 | Block enable |
| flagClr | input | 1 | Clears all status flags |
| irqFlag | output | 1 | Byte complete |
| ovfFlag | output | 1 | Byte lost to an unread buffer |
| wcolFlag | output | 1 | Write during an active frame |
| modeErr | output | 1 | cke=1 requested without select gating |

## Verification
A register-side read strobe and the completion of a received byte can land on the same system clock edge. Which one wins decides whether an overflow is reported. The bench places bufRd across the exact edge on which the synchronized eighth sample edge commits: two system clocks after the first clock edge that sees the sck change. It then checks that no overflow appears and that the new byte is on bufRdData. A further frame without a read must then overflow, which shows that the new byte was kept as unread.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  typedef struct packed {
    logic active;     // slave selected and enabled
    logic sampleStb;  // take one sdi bit
    logic shiftStb;   // advance the transmit register
    logic frameDone;  // last bit of the byte sampled
    logic inFrame;    // some bits of a byte already taken
    logic sdiBit;     // synchronized serial input
  } spi_strobe_t;
endpackage

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W = 4,
  parameter logic [MODE_W-1:0] SEL_CODE = 4'b0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              ssN,
  input  logic              sdi,
  input  logic [MODE_W-1:0] mode,
  input  logic              cpol,
  input  logic              cke,
  input  logic              enable,
  output spi_strobe_t       stb,
  output logic              modeErr
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckPipe, ssPipe, sdiPipe;
  logic sckPrev;
  logic sckS, ssS, sdiS;
  logic selCtl, effCke, active;
  logic leadEdge, trailEdge, sampleEdge, changeEdge;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      ssPipe  <= '1;
      sdiPipe <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sck};
      ssPipe  <= {ssPipe[SYNC_STAGES-2:0], ssN};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      sckPrev <= sckPipe[SYNC_STAGES-1];
    end
  end

  assign sckS = sckPipe[SYNC_STAGES-1];
  assign ssS  = ssPipe[SYNC_STAGES-1];
  assign sdiS = sdiPipe[SYNC_STAGES-1];

  assign selCtl  = (mode == SEL_CODE);
  assign active  = enable && (!selCtl || !ssS);
  assign effCke  = cke && selCtl;
  assign modeErr = enable && cke && !selCtl;

  assign leadEdge   = (sckS != cpol) && (sckPrev == cpol);
  assign trailEdge  = (sckS == cpol) && (sckPrev != cpol);
  assign sampleEdge = effCke ? leadEdge : trailEdge;
  assign changeEdge = effCke ? trailEdge : leadEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (!active) bitCnt <= '0;
    else if (sampleEdge) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    stb.active    = active;
    stb.sampleStb = active && sampleEdge;
    stb.shiftStb  = active && changeEdge && (bitCnt != '0);
    stb.frameDone = active && sampleEdge && (bitCnt == LAST_BIT);
    stb.inFrame   = active && (bitCnt != '0);
    stb.sdiBit    = sdiS;
  end

  p_cnt_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == '0));
  p_quiet_deselect_r5: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !(stb.sampleStb || stb.shiftStb || stb.frameDone));
  p_done_wraps_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> (bitCnt == '0));
  p_moderr_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && stb.sampleStb) |-> (sckS == cpol));
endmodule

// File: rtl/spi_sel_dpath.sv
module spi_sel_dpath
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobe_t       stb,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRd,
  input  logic              flagClr,
  output logic [DATA_W-1:0] bufRdData,
  output logic              txMsb,
  output logic              irqFlag,
  output logic              ovfFlag,
  output logic              wcolFlag
);
  logic [DATA_W-1:0] rxShift, rxBuf, txShift, newByte;
  logic bufFull;

  assign newByte   = {rxShift[DATA_W-2:0], stb.sdiBit};
  assign bufRdData = rxBuf;
  assign txMsb     = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBuf   <= '0;
      bufFull <= 1'b0;
      ovfFlag <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (flagClr) begin
        ovfFlag <= 1'b0;
        irqFlag <= 1'b0;
      end
      if (bufRd) bufFull <= 1'b0;
      if (stb.sampleStb) rxShift <= newByte;
      if (stb.frameDone) begin
        irqFlag <= 1'b1;
        if (bufFull && !bufRd) ovfFlag <= 1'b1;
        else begin
          rxBuf   <= newByte;
          bufFull <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      wcolFlag <= 1'b0;
    end else begin
      if (flagClr) wcolFlag <= 1'b0;
      if (bufWr && stb.inFrame) wcolFlag <= 1'b1;
      if (stb.frameDone) txShift <= '0;
      else if (bufWr && !stb.inFrame) txShift <= bufWrData;
      else if (stb.shiftStb) txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  p_irq_on_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> irqFlag);
  p_ovf_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameDone && bufFull && !bufRd) |=> (ovfFlag && $stable(rxBuf)));
  p_tx_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> (txShift == '0));
  p_wcol_r11: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && stb.inFrame && !stb.shiftStb && !stb.frameDone) |=> (wcolFlag && $stable(txShift)));
  p_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !stb.frameDone && !bufWr) |=> (!irqFlag && !ovfFlag && !wcolFlag));
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W = 4,
  parameter logic [MODE_W-1:0] SEL_CODE = 4'b0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              ssN,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRd,
  output logic [DATA_W-1:0] bufRdData,
  input  logic [MODE_W-1:0] mode,
  input  logic              cpol,
  input  logic              cke,
  input  logic              enable,
  input  logic              flagClr,
  output logic              irqFlag,
  output logic              ovfFlag,
  output logic              wcolFlag,
  output logic              modeErr
);
  spi_strobe_t stb;

  spi_sel_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .MODE_W(MODE_W), .SEL_CODE(SEL_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .sdi(sdi), .mode(mode),
    .cpol(cpol), .cke(cke), .enable(enable), .stb(stb), .modeErr(modeErr)
  );

  spi_sel_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bufWr(bufWr), .bufWrData(bufWrData),
    .bufRd(bufRd), .flagClr(flagClr), .bufRdData(bufRdData), .txMsb(sdo),
    .irqFlag(irqFlag), .ovfFlag(ovfFlag), .wcolFlag(wcolFlag)
  );

  assign sdoOe = stb.active;

  p_float_deselect_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == SEL_CODE) && $past(ssN) && ssN && $past(ssN, 2) && $past(ssN, 3)) |-> !sdoOe);
endmodule

// File: tb/spi_sel_slave_bench.sv
module spi_sel_slave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, ssN = 1'b1, sdi = 1'b0;
  logic sdo, sdoOe;
  logic bufWr = 1'b0, bufRd = 1'b0, flagClr = 1'b0;
  logic [7:0] bufWrData = 8'h00;
  logic [7:0] bufRdData;
  logic [3:0] mode = 4'b0100;
  logic cpol = 1'b0, cke = 1'b0, enable = 1'b0;
  logic irqFlag, ovfFlag, wcolFlag, modeErr;
  int total = 0, bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_sel_slave u_spi_sel_slave (
    .clk(clk), .rstN(rstN), .sck(sck), .ssN(ssN), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe),
    .bufWr(bufWr), .bufWrData(bufWrData), .bufRd(bufRd), .bufRdData(bufRdData),
    .mode(mode), .cpol(cpol), .cke(cke), .enable(enable), .flagClr(flagClr),
    .irqFlag(irqFlag), .ovfFlag(ovfFlag), .wcolFlag(wcolFlag), .modeErr(modeErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit effCke();
    return cke && (mode == 4'b0100);
  endfunction

  task automatic wrBuf(input logic [7:0] d);
    bufWrData = d; bufWr = 1'b1; tick(1); bufWr = 1'b0; tick(1);
  endtask

  task automatic rdClr();
    bufRd = 1'b1; flagClr = 1'b1; tick(1); bufRd = 1'b0; flagClr = 1'b0; tick(1);
  endtask

  task automatic xfer(input logic [7:0] mosi, input int nbits, input bit rdAtDone,
                      output logic [7:0] miso);
    miso = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      sdi = mosi[7-i];
      tick(3);
      if (effCke()) miso = {miso[6:0], sdo};
      sck = ~cpol;
      if (rdAtDone && effCke() && i == nbits - 1) begin
        tick(2); bufRd = 1'b1; tick(1); bufRd = 1'b0; tick(3);
      end else tick(6);
      if (!effCke()) miso = {miso[6:0], sdo};
      sck = cpol;
      tick(3);
    end
    tick(4);
  endtask

  logic [7:0] m, tx;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 irq", {7'd0, irqFlag}, 8'h00);
    chk("R1 ovf", {7'd0, ovfFlag}, 8'h00);
    chk("R1 wcol", {7'd0, wcolFlag}, 8'h00);
    chk("R1 oe", {7'd0, sdoOe}, 8'h00);
    chk("R1 data", bufRdData, 8'h00);

    enable = 1'b1; mode = 4'b0100;
    for (int pc = 0; pc < 4; pc++) begin
      ssN = 1'b1; cpol = pc[1]; cke = pc[0]; sck = cpol; tick(4);
      for (int v = 0; v < 256; v += 5) begin
        tx = 8'(v) ^ 8'h5A;
        wrBuf(tx);
        ssN = 1'b0; tick(4);
        chk("R5 oe on", {7'd0, sdoOe}, 8'h01);
        xfer(8'(v), 8, 1'b0, m);
        chk("R2 irq", {7'd0, irqFlag}, 8'h01);
        chk("R2 rx", bufRdData, 8'(v));
        chk("R3 tx", m, tx);
        rdClr();
        chk("R12 clr", {7'd0, irqFlag}, 8'h00);
        ssN = 1'b1; tick(4);
        chk("R5 oe off", {7'd0, sdoOe}, 8'h00);
      end
    end

    // R4: no fresh write
    cpol = 1'b0; cke = 1'b1; sck = 1'b0; tick(4);
    ssN = 1'b0; tick(4);
    xfer(8'h81, 8, 1'b0, m);
    chk("R4 empty tx", m, 8'h00);
    rdClr(); ssN = 1'b1; tick(4);

    // R5: partial frame dropped
    ssN = 1'b0; tick(4);
    xfer(8'hFF, 3, 1'b0, m);
    ssN = 1'b1; tick(4);
    chk("R5 no irq", {7'd0, irqFlag}, 8'h00);
    ssN = 1'b0; tick(4);
    xfer(8'hC3, 8, 1'b0, m);
    chk("R5 aligned", bufRdData, 8'hC3);
    rdClr(); ssN = 1'b1; tick(4);

    // R9: overflow
    ssN = 1'b0; tick(4);
    xfer(8'h11, 8, 1'b0, m);
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
    xfer(8'h22, 8, 1'b0, m);
    chk("R9 ovf", {7'd0, ovfFlag}, 8'h01);
    chk("R9 keep", bufRdData, 8'h11);
    chk("R9 irq", {7'd0, irqFlag}, 8'h01);
    rdClr();
    chk("R12 ovf clr", {7'd0, ovfFlag}, 8'h00);

    // R10: read at completion
    xfer(8'h33, 8, 1'b0, m);
    xfer(8'h44, 8, 1'b1, m);
    chk("R10 no ovf", {7'd0, ovfFlag}, 8'h00);
    chk("R10 new", bufRdData, 8'h44);
    xfer(8'h55, 8, 1'b0, m);
    chk("R10 unread", {7'd0, ovfFlag}, 8'h01);
    chk("R10 held", bufRdData, 8'h44);
    rdClr(); ssN = 1'b1; tick(4);

    // R11: write collision
    wrBuf(8'h77);
    ssN = 1'b0; tick(4);
    xfer(8'hA0, 3, 1'b0, m);
    wrBuf(8'h99);
    chk("R11 wcol", {7'd0, wcolFlag}, 8'h01);
    xfer(8'h00, 5, 1'b0, m);
    chk("R11 tail", m, 8'h17);
    chk("R11 rx", bufRdData, 8'hA0);
    rdClr();
    chk("R12 wcol clr", {7'd0, wcolFlag}, 8'h00);
    xfer(8'h0F, 8, 1'b0, m);
    chk("R11 ignored", m, 8'h00);
    rdClr(); ssN = 1'b1; tick(4);

    // R6: select ignored in other mode
    enable = 1'b0; mode = 4'b0101; cke = 1'b0; cpol = 1'b1; sck = 1'b1; tick(4);
    enable = 1'b1; tick(4);
    chk("R6 oe", {7'd0, sdoOe}, 8'h01);
    chk("R8 no err", {7'd0, modeErr}, 8'h00);
    wrBuf(8'hA6);
    xfer(8'h3C, 8, 1'b0, m);
    chk("R6 rx", bufRdData, 8'h3C);
    chk("R6 tx", m, 8'hA6);
    rdClr();

    // R8: cke=1 illegal here, acts as cke=0
    cke = 1'b1; tick(1);
    chk("R8 err", {7'd0, modeErr}, 8'h01);
    wrBuf(8'h5C);
    xfer(8'hD2, 8, 1'b0, m);
    chk("R8 rx", bufRdData, 8'hD2);
    chk("R8 tx", m, 8'h5C);
    rdClr();
    cke = 1'b0;

    // R7: enable drop
    xfer(8'hFF, 5, 1'b0, m);
    enable = 1'b0; tick(4);
    chk("R7 oe", {7'd0, sdoOe}, 8'h00);
    chk("R7 no irq", {7'd0, irqFlag}, 8'h00);
    enable = 1'b1; tick(4);
    xfer(8'h6B, 8, 1'b0, m);
    chk("R7 aligned", bufRdData, 8'h6B);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule